// File: doc/BRIEF.md
# Event Combiner and Router

This block routes system events to one processor core. Sixty-four event channels arrive at its input. Two combiners sit over fixed, disjoint halves of the channel space. Each combiner latches rising edges of its raw events into sticky flags, gates those flags with per-channel enable bits, and ORs the result into one combined event. The two combined events are fed back into the same channel space as channels 0 and 1.

Sixteen outputs face the core. Each output has its own 6-bit selector, which picks any one of the 64 channels, combined channels included. Ordinary channels (4 to 63) pass raw from input to output through combinational logic only. Channels 2 and 3 are reserved and always read as zero.

A small register bus configures the enables and selectors. Through the same bus, software reads the raw and the enabled flag state of each combiner and clears flags.

Top module: `evtRouter`

## Requirements
- R1: After reset all enable bits and all flags are 0, and every selector holds channel 2 (a reserved channel). Every output is therefore 0, and a read of each selector word (addresses 8 to 11) returns 0x02020202.
- R2: A rising edge on raw channel c, for c from 4 to 63, sets sticky flag c on the next clock edge. The flag stays set while the raw input is low. Flag c for c below 32 is bit c at address 2. Flag c for c of 32 or more is bit c-32 at address 3.
- R3: Writing 1 to a flag bit (address 2 or 3) clears it on the next clock edge. Writing 0 leaves the bit as it is. A rising edge in the same cycle as the clear wins, so the flag stays set.
- R4: Raw channels 0 to 3 never set a flag, so bits 3:0 at address 2 always read 0. An output that selects channel 2 or 3 is always 0.
- R5: Combined event 0 (channel 0) is 1 exactly when some flag c, for c from 4 to 31, is set and its enable bit is 1. Combined event 1 (channel 1) is the same over flags 32 to 63. The enable bits sit at address 0 (bit c) and address 1 (bit c-32). An enable bit of 1 includes the channel.
- R6: A read of address 4 returns flag AND enable for the low half, and a read of address 5 returns the same for the high half.
- R7: Output k equals the value of the channel its selector names. For channels 4 to 63 this is the raw input in the same cycle, with no register in between.
- R8: Selector k lives at address 8 + k/4, in bits [5:0] of byte k mod 4 of the data word. A write takes effect on the output in the cycle after the write cycle and leaves every other selector unchanged.
- R9: Reads are combinational. A read of an unmapped address (6, 7, 12 to 15) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rawEvt | input | 64 | Raw event channels; bits 3:0 are ignored |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Register word address |
| busWData | input | 32 | Register write data |
| busRData | output | 32 | Register read data for busAddr |
| evtOut | output | 16 | Selected events toward the core |

## Verification
The assertions check the flag and combine rules on every cycle: a rising edge always leaves its flag set, a flag falls only after a clear write, the reserved low flags stay zero, combined event 0 stays low while its enables are zero, the enabled readback is a subset of the flags, and unmapped reads return zero. Other behaviour can only be shown by the bench's scenarios, which compare the block against a behavioural model every cycle. These behaviours are the timing of a selector change, the independence of the sixteen selectors, set-over-clear priority, same-cycle raw pass-through, and the exact combined value under mixed enables.

// File: rtl/evtRouterPkg.sv
package evtRouterPkg;
  localparam int NUM_CH     = 64;
  localparam int DATA_W     = 32;
  localparam int SEL_W      = $clog2(NUM_CH);
  localparam int ADDR_W     = 4;
  localparam int BYTE_W     = 8;
  localparam int SEL_PER_WD = DATA_W / BYTE_W;
  localparam int FIRST_LIVE = 4;
  localparam int RESET_SEL  = 2;
  localparam int SEL_BASE   = 8;
  localparam int A_EN_LO    = 0;
  localparam int A_EN_HI    = 1;
  localparam int A_FL_LO    = 2;
  localparam int A_FL_HI    = 3;
  localparam int A_PD_LO    = 4;
  localparam int A_PD_HI    = 5;

  typedef struct packed {
    logic              clrLo;
    logic              clrHi;
    logic [DATA_W-1:0] clrBits;
  } dpStrobe_t;
endpackage

// File: rtl/evtRouterCtrl.sv
module evtRouterCtrl
  import evtRouterPkg::*;
#(
  parameter int NUM_OUT = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busWrEn,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [DATA_W-1:0]        busWData,
  input  logic [DATA_W-1:0]        flagLo,
  input  logic [DATA_W-1:0]        flagHi,
  output dpStrobe_t                strobe,
  output logic [DATA_W-1:0]        enLo,
  output logic [DATA_W-1:0]        enHi,
  output logic [NUM_OUT*SEL_W-1:0] selFlat,
  output logic [DATA_W-1:0]        busRData
);
  localparam int SEL_WORDS = (NUM_OUT + SEL_PER_WD - 1) / SEL_PER_WD;
  localparam int PAD_W     = BYTE_W - SEL_W;

  logic [SEL_W-1:0]  selReg [NUM_OUT];
  logic [DATA_W-1:0] selWord [SEL_WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enLo <= '0;
      enHi <= '0;
      for (int k = 0; k < NUM_OUT; k++) selReg[k] <= SEL_W'(RESET_SEL);
    end else if (busWrEn) begin
      if (busAddr == ADDR_W'(A_EN_LO)) enLo <= busWData;
      if (busAddr == ADDR_W'(A_EN_HI)) enHi <= busWData;
      for (int k = 0; k < NUM_OUT; k++) begin
        if (busAddr == ADDR_W'(SEL_BASE + k / SEL_PER_WD))
          selReg[k] <= busWData[(k % SEL_PER_WD)*BYTE_W +: SEL_W];
      end
    end
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_selOut
    assign selFlat[k*SEL_W +: SEL_W] = selReg[k];
  end

  for (genvar w = 0; w < SEL_WORDS; w++) begin : g_selWord
    for (genvar b = 0; b < SEL_PER_WD; b++) begin : g_lane
      if (w * SEL_PER_WD + b < NUM_OUT) begin : g_used
        assign selWord[w][b*BYTE_W +: BYTE_W] = {{PAD_W{1'b0}}, selReg[w*SEL_PER_WD + b]};
      end else begin : g_spare
        assign selWord[w][b*BYTE_W +: BYTE_W] = '0;
      end
    end
  end

  assign strobe.clrLo   = busWrEn && (busAddr == ADDR_W'(A_FL_LO));
  assign strobe.clrHi   = busWrEn && (busAddr == ADDR_W'(A_FL_HI));
  assign strobe.clrBits = busWData;

  always_comb begin
    busRData = '0;
    case (busAddr)
      ADDR_W'(A_EN_LO): busRData = enLo;
      ADDR_W'(A_EN_HI): busRData = enHi;
      ADDR_W'(A_FL_LO): busRData = flagLo;
      ADDR_W'(A_FL_HI): busRData = flagHi;
      ADDR_W'(A_PD_LO): busRData = flagLo & enLo;
      ADDR_W'(A_PD_HI): busRData = flagHi & enHi;
      default: begin
        for (int w = 0; w < SEL_WORDS; w++)
          if (busAddr == ADDR_W'(SEL_BASE + w)) busRData = selWord[w];
      end
    endcase
  end
endmodule

// File: rtl/evtRouterDp.sv
module evtRouterDp
  import evtRouterPkg::*;
#(
  parameter int NUM_OUT = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        rawEvt,
  input  dpStrobe_t                strobe,
  input  logic [DATA_W-1:0]        enLo,
  input  logic [DATA_W-1:0]        enHi,
  input  logic [NUM_OUT*SEL_W-1:0] selFlat,
  output logic [DATA_W-1:0]        flagLo,
  output logic [DATA_W-1:0]        flagHi,
  output logic                     combLo,
  output logic                     combHi,
  output logic [NUM_OUT-1:0]       evtOut
);
  localparam logic [NUM_CH-1:0] LIVE_MASK = {{(NUM_CH-FIRST_LIVE){1'b1}}, {FIRST_LIVE{1'b0}}};

  logic [NUM_CH-1:0] prevRaw;
  logic [NUM_CH-1:0] flagAll;
  logic [NUM_CH-1:0] riseVec;
  logic [NUM_CH-1:0] clrVec;
  logic [NUM_CH-1:0] chanVec;

  assign riseVec = rawEvt & ~prevRaw & LIVE_MASK;
  assign clrVec  = {strobe.clrHi ? strobe.clrBits : '0,
                    strobe.clrLo ? strobe.clrBits : '0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRaw <= '0;
      flagAll <= '0;
    end else begin
      prevRaw <= rawEvt;
      flagAll <= (flagAll & ~clrVec) | riseVec;
    end
  end

  assign flagLo = flagAll[DATA_W-1:0];
  assign flagHi = flagAll[NUM_CH-1:DATA_W];
  assign combLo = |(flagLo & enLo);
  assign combHi = |(flagHi & enHi);

  assign chanVec = {rawEvt[NUM_CH-1:FIRST_LIVE], 2'b00, combHi, combLo};

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_route
    assign evtOut[k] = chanVec[selFlat[k*SEL_W +: SEL_W]];
  end
endmodule

// File: rtl/evtRouter.sv
module evtRouter
  import evtRouterPkg::*;
#(
  parameter int NUM_OUT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [63:0]        rawEvt,
  input  logic               busWrEn,
  input  logic [3:0]         busAddr,
  input  logic [31:0]        busWData,
  output logic [31:0]        busRData,
  output logic [NUM_OUT-1:0] evtOut
);
  dpStrobe_t                strobe;
  logic [DATA_W-1:0]        enLo;
  logic [DATA_W-1:0]        enHi;
  logic [DATA_W-1:0]        flagLo;
  logic [DATA_W-1:0]        flagHi;
  logic                     combLo;
  logic                     combHi;
  logic [NUM_OUT*SEL_W-1:0] selFlat;

  evtRouterCtrl #(.NUM_OUT(NUM_OUT)) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWData(busWData), .flagLo(flagLo), .flagHi(flagHi),
    .strobe(strobe), .enLo(enLo), .enHi(enHi), .selFlat(selFlat),
    .busRData(busRData)
  );

  evtRouterDp #(.NUM_OUT(NUM_OUT)) uDp (
    .clk(clk), .rstN(rstN), .rawEvt(rawEvt), .strobe(strobe),
    .enLo(enLo), .enHi(enHi), .selFlat(selFlat), .flagLo(flagLo),
    .flagHi(flagHi), .combLo(combLo), .combHi(combHi), .evtOut(evtOut)
  );
endmodule

// File: rtl/evtRouterChk.sv
module evtRouterChk (
  input logic        clk,
  input logic        rstN,
  input logic [63:0] rawEvt,
  input logic        busWrEn,
  input logic [3:0]  busAddr,
  input logic [31:0] busRData,
  input logic [31:0] flagLo,
  input logic [31:0] flagHi,
  input logic [31:0] enLo,
  input logic        combLo
);
  // R2
  rise_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(rawEvt[63:32]) & ~$past(rawEvt[63:32], 2)) & ~flagHi) == 32'd0));

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busWrEn && busAddr == 4'd2) |-> (((~flagLo) & $past(flagLo)) == 32'd0));

  // R4
  reserved_flags_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 4'd2) |-> (busRData[3:0] == 4'd0));

  // R5
  comb_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enLo == 32'd0) |-> !combLo);

  // R6
  pending_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 4'd4) |-> ((busRData & ~flagLo) == 32'd0));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 4'd6 || busAddr == 4'd7 || busAddr >= 4'd12) |-> (busRData == 32'd0));
endmodule

bind evtRouter evtRouterChk uChk (
  .clk(clk), .rstN(rstN), .rawEvt(rawEvt), .busWrEn(busWrEn),
  .busAddr(busAddr), .busRData(busRData), .flagLo(flagLo),
  .flagHi(flagHi), .enLo(enLo), .combLo(combLo)
);

// File: tb/evtRouter_test.sv
module evtRouter_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] rawEvt = '0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic [15:0] evtOut;

  evtRouter uut (
    .clk(clk), .rstN(rstN), .rawEvt(rawEvt), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .evtOut(evtOut)
  );

  always #(PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";

  // behavioural reference state
  bit mFlag [64];
  bit mPrev [64];
  bit mEn   [64];
  int mSel  [16];

  function automatic bit chanVal(int c);
    if (c == 0 || c == 1) begin
      for (int i = 4; i < 64; i++)
        if ((i / 32) == c && mFlag[i] && mEn[i]) return 1'b1;
      return 1'b0;
    end
    if (c < 4) return 1'b0;
    return rawEvt[c];
  endfunction

  function automatic logic [31:0] expRead(int a);
    logic [31:0] v = '0;
    if (a <= 5) begin
      for (int b = 0; b < 32; b++) begin
        int c = (a % 2) * 32 + b;
        if (a < 2)      v[b] = mEn[c];
        else if (a < 4) v[b] = mFlag[c];
        else            v[b] = mFlag[c] & mEn[c];
      end
    end else if (a >= 8 && a <= 11) begin
      for (int b = 0; b < 4; b++) v[b*8 +: 8] = 8'(mSel[(a - 8) * 4 + b]);
    end
    return v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < 64; c++) begin mFlag[c] = 0; mPrev[c] = 0; mEn[c] = 0; end
      for (int k = 0; k < 16; k++) mSel[k] = 2;
    end else begin
      for (int c = 4; c < 64; c++) begin
        if (rawEvt[c] && !mPrev[c]) mFlag[c] = 1;
        else if (busWrEn && busAddr == 4'(2 + c / 32) && busWData[c % 32]) mFlag[c] = 0;
      end
      for (int c = 0; c < 64; c++) mPrev[c] = rawEvt[c];
      if (busWrEn && busAddr <= 4'd1)
        for (int b = 0; b < 32; b++) mEn[int'(busAddr) * 32 + b] = busWData[b];
      if (busWrEn && busAddr >= 4'd8 && busAddr <= 4'd11)
        for (int b = 0; b < 4; b++)
          mSel[(int'(busAddr) - 8) * 4 + b] = int'((busWData >> (b * 8)) & 32'h3f);
    end
  end

  always @(negedge clk) begin
    logic [15:0] eo;
    logic [31:0] er;
    for (int k = 0; k < 16; k++) eo[k] = chanVal(mSel[k]);
    er = expRead(int'(busAddr));
    compared++;
    if (evtOut !== eo) begin
      mismatched++;
      $display("FAIL %s evtOut actual=%h expected=%h t=%0t", curReq, evtOut, eo, $time);
    end
    compared++;
    if (busRData !== er) begin
      mismatched++;
      $display("FAIL %s read addr=%0d actual=%h expected=%h t=%0t", curReq, busAddr, busRData, er, $time);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWData = d;
    step();
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    busAddr = a;
    step();
  endtask

  initial begin
    #(PERIOD * 20000);
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step();
    for (int a = 0; a < 12; a++) rd(4'(a));

    // R7: raw pass-through on ordinary channels
    curReq = "R7";
    wr(4'd8, 32'h3f_04_3f_0a);          // sel0=10 sel1=63 sel2=4 sel3=63
    wr(4'd9, 32'h20_1f_05_21);
    for (int i = 0; i < 6; i++) begin
      rawEvt = {$urandom, $urandom} & 64'hffff_ffff_ffff_fff0;
      step();
    end
    rawEvt = '0; step();

    // R8: selector change timing and independence
    curReq = "R8";
    rawEvt = 64'h8000_0000_0000_0400;
    wr(4'd8, 32'h3f_04_3f_3f);
    wr(4'd11, 32'h0a_0a_3f_0a);
    rd(4'd8); rd(4'd9); rd(4'd10); rd(4'd11);
    rawEvt = '0; step();

    // R2: rising edges latch sticky flags
    curReq = "R2";
    rawEvt[5] = 1'b1; rawEvt[40] = 1'b1; step();
    rawEvt = '0; rd(4'd2); rd(4'd3);
    rawEvt[63] = 1'b1; rd(4'd3); rd(4'd3);

    // R3: write-one-to-clear, set wins
    curReq = "R3";
    wr(4'd2, 32'h0000_0000);
    wr(4'd2, 32'h0000_0020);
    rd(4'd2);
    rawEvt = '0; step();
    rawEvt[63] = 1'b1;
    wr(4'd3, 32'h8000_0100);
    rd(4'd3);

    // R4: low channels ignored
    curReq = "R4";
    wr(4'd8, 32'h3f_3f_03_02);
    rawEvt[3:0] = 4'hf; step();
    rawEvt[3:0] = 4'h0; step();
    rawEvt[3:0] = 4'hf; rd(4'd2);

    // R5: combined events with mixed enables
    curReq = "R5";
    wr(4'd8, 32'h3f_3f_01_00);
    wr(4'd3, 32'hffff_ffff);
    wr(4'd2, 32'hffff_ffff);
    rawEvt = '0; step();
    rawEvt[9] = 1'b1; rawEvt[50] = 1'b1; step();
    wr(4'd0, 32'h0000_0100);
    wr(4'd0, 32'h0000_0200);
    wr(4'd1, 32'h0004_0000);
    wr(4'd2, 32'h0000_0200);
    wr(4'd3, 32'h0004_0000);

    // R6: enabled readback
    curReq = "R6";
    rawEvt = '0; step();
    rawEvt = 64'hffff_ffff_ffff_ffff; step();
    wr(4'd0, 32'h00f0_f0f0);
    wr(4'd1, 32'h1234_5678);
    rd(4'd4); rd(4'd5); rd(4'd2); rd(4'd3);

    // R9: unmapped addresses
    curReq = "R9";
    rd(4'd6); rd(4'd7);
    for (int a = 12; a < 16; a++) rd(4'(a));

    // mixed traffic across all behaviours
    curReq = "R7";
    for (int i = 0; i < 300; i++) begin
      rawEvt = {$urandom, $urandom};
      case ($urandom % 4)
        0: wr(4'($urandom % 16), $urandom);
        default: rd(4'($urandom % 16));
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule